// File: doc/BRIEF.md
# AXI Transaction Status and Error Tracker

This block sits beside the AXI slave port of a serial memory controller and watches its read and write channels. For each direction it keeps an activity flag. The flag rises when an address handshake is accepted. It falls when the transaction completes: the final read data beat, or the write response handshake. Only one transaction per direction may be outstanding, so the block holds the address-ready signal of a direction low while that direction is busy.

While a transaction is in flight, the block collects the error indications that the backend raises. These are an unreachable address, an unsupported protocol form, and the memory being held in reset. Reads can also end in a strobe stall, which the block detects itself: once a read has been issued to the memory, it counts clock cycles, and if no strobe edge arrives within a parameterised number of cycles it records a stall. From the collected errors it drives the response code on every read beat and on the write response.

When a transaction completes, the collected flags replace the error flags of that direction. All flags are presented in a 32-bit read-only status word. Moving data and driving the memory-side bus are handled elsewhere.

Top module: `axi_txn_monitor`

## Requirements
- R1: Bit 0 of the status word (read busy) becomes 1 on the clock edge that accepts `ar_valid && ar_ready`. It becomes 0 on the edge that accepts a read beat with `r_valid && r_ready && r_last`.
- R2: Bit 16 of the status word (write busy) becomes 1 on the edge that accepts `aw_valid && aw_ready`. It becomes 0 on the edge that accepts `b_valid && b_ready`.
- R3: `ar_ready` is 0 whenever bit 0 is set, and 1 otherwise. `aw_ready` is 0 whenever bit 16 is set, and 1 otherwise.
- R4: After a read completes, status bits 8, 9 and 10 are 1 if the address-decode, protocol or memory-reset input, respectively, was high in any cycle while that read was busy. Otherwise each is 0.
- R5: After a write completes, status bits 24, 25 and 26 are 1 if the address-decode, protocol or memory-reset input, respectively, was high in any cycle while that write was busy. Otherwise each is 0.
- R6: `rresp` and `bresp` carry 2'b11 if an address-decode error has been seen in the current transaction, up to and including the current cycle. Otherwise they carry 2'b10 if any other error has been seen, including a read stall for `rresp`. Otherwise they carry 2'b00. DECERR takes priority, and every flag is still recorded.
- R7: A read is flagged as stalled if, after `rd_issue` is sampled during the read, STALL_CYCLES consecutive clock edges pass with `rd_strobe_edge` low. The stall appears in status bit 11 after completion and in `rresp` from that point on.
- R8: The error flags of a direction are replaced, not accumulated, when that direction completes. Between completions they hold their value, including during activity in the other direction.
- R9: Status bits 31:27, 23:17, 15:12 and 7:1 always read 0, and the whole word is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address ready (low while a read is busy) |
| r_valid | input | 1 | Read data beat valid |
| r_ready | input | 1 | Read data beat ready |
| r_last | input | 1 | Final read data beat |
| rresp | output | 2 | Response code for the current read beat |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address ready (low while a write is busy) |
| b_valid | input | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| bresp | output | 2 | Response code for the write response |
| rd_dec_err | input | 1 | Backend: read address not reachable |
| rd_proto_err | input | 1 | Backend: read form not supported |
| rd_mem_rst | input | 1 | Backend: memory in reset during read |
| rd_issue | input | 1 | Read has been issued to the memory; starts stall timing |
| rd_strobe_edge | input | 1 | A read strobe edge arrived from the memory |
| wr_dec_err | input | 1 | Backend: write address not reachable |
| wr_proto_err | input | 1 | Backend: write form not supported |
| wr_mem_rst | input | 1 | Backend: memory in reset during write |
| status | output | 32 | Read-only status word |

## Verification
Reads are tried with all eight combinations of the three backend error inputs, each with and without a strobe stall, and with bursts of one to three beats. This shows that DECERR wins over SLVERR on every beat, that each flag lands in its own bit, and that the busy flag falls only on the final beat. Writes sweep the same eight combinations. Because the error patterns change from one transaction to the next, a flag that accumulates instead of being replaced shows up. Checking the read bits after writes, and the write bits after reads, separates the two directions.

// File: rtl/axi_txn_monitor.sv
module axi_txn_monitor #(
  parameter int STALL_CYCLES = 16,
  localparam int CW = (STALL_CYCLES > 2) ? $clog2(STALL_CYCLES) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ar_valid,
  output logic        ar_ready,
  input  logic        r_valid,
  input  logic        r_ready,
  input  logic        r_last,
  output logic [1:0]  rresp,
  input  logic        aw_valid,
  output logic        aw_ready,
  input  logic        b_valid,
  input  logic        b_ready,
  output logic [1:0]  bresp,
  input  logic        rd_dec_err,
  input  logic        rd_proto_err,
  input  logic        rd_mem_rst,
  input  logic        rd_issue,
  input  logic        rd_strobe_edge,
  input  logic        wr_dec_err,
  input  logic        wr_proto_err,
  input  logic        wr_mem_rst,
  output logic [31:0] status
);

  localparam logic [1:0] OKAY   = 2'b00;
  localparam logic [1:0] SLVERR = 2'b10;
  localparam logic [1:0] DECERR = 2'b11;

  function automatic logic [1:0] pick_resp(input logic dec, input logic other);
    return dec ? DECERR : (other ? SLVERR : OKAY);
  endfunction

  logic          rd_busy, wr_busy;
  logic [2:0]    rd_seen, wr_seen;
  logic          stall_seen, armed;
  logic [CW-1:0] wait_cnt;
  logic [3:0]    rd_flags;
  logic [2:0]    wr_flags;

  wire ar_take = ar_valid && ar_ready;
  wire aw_take = aw_valid && aw_ready;
  wire r_end   = rd_busy && r_valid && r_ready && r_last;
  wire b_end   = wr_busy && b_valid && b_ready;

  wire [2:0] rd_all = rd_seen | ({3{rd_busy}} & {rd_mem_rst, rd_proto_err, rd_dec_err});
  wire [2:0] wr_all = wr_seen | ({3{wr_busy}} & {wr_mem_rst, wr_proto_err, wr_dec_err});

  assign ar_ready = !rd_busy;
  assign aw_ready = !wr_busy;
  assign rresp    = pick_resp(rd_all[0], |{stall_seen, rd_all[2:1]});
  assign bresp    = pick_resp(wr_all[0], |wr_all[2:1]);
  assign status   = {5'b0, wr_flags, 7'b0, wr_busy, 4'b0, rd_flags, 7'b0, rd_busy};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_busy  <= 1'b0;
      rd_seen  <= '0;
      rd_flags <= '0;
    end else if (ar_take) begin
      rd_busy <= 1'b1;
      rd_seen <= '0;
    end else if (r_end) begin
      rd_busy  <= 1'b0;
      rd_flags <= {stall_seen, rd_all};
    end else begin
      rd_seen <= rd_all;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_busy  <= 1'b0;
      wr_seen  <= '0;
      wr_flags <= '0;
    end else if (aw_take) begin
      wr_busy <= 1'b1;
      wr_seen <= '0;
    end else if (b_end) begin
      wr_busy  <= 1'b0;
      wr_flags <= wr_all;
    end else begin
      wr_seen <= wr_all;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_seen <= 1'b0;
      armed      <= 1'b0;
      wait_cnt   <= '0;
    end else if (ar_take) begin
      stall_seen <= 1'b0;
      armed      <= 1'b0;
    end else if (!rd_busy || r_end) begin
      armed <= 1'b0;
    end else if (rd_issue) begin
      armed    <= 1'b1;
      wait_cnt <= '0;
    end else if (armed) begin
      if (rd_strobe_edge) begin
        armed <= 1'b0;
      end else if (wait_cnt == CW'(STALL_CYCLES - 1)) begin
        stall_seen <= 1'b1;
        armed      <= 1'b0;
      end else begin
        wait_cnt <= wait_cnt + 1'b1;
      end
    end
  end

  a_r1_rd_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && ar_ready) |=> status[0]);
  a_r1_rd_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && r_valid && r_ready && r_last) |=> !status[0]);
  a_r2_wr_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (status[16] && b_valid && b_ready) |=> !status[16]);
  a_r3_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> !ar_ready);
  a_r3_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    status[16] |-> !aw_ready);
  a_r6_dec_first: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && rd_dec_err) |-> (rresp == DECERR));
  a_r8_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[0] && r_valid && r_ready && r_last) |=> $stable(status[11:8]));
  a_r8_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[16] && b_valid && b_ready) |=> $stable(status[26:24]));

endmodule

// File: tb/axi_txn_monitor_test.sv
module axi_txn_monitor_test;
  localparam int STALL = 4;

  logic clk = 0, rst_n = 0;
  logic ar_valid = 0, r_valid = 0, r_ready = 0, r_last = 0;
  logic aw_valid = 0, b_valid = 0, b_ready = 0;
  logic rd_dec_err = 0, rd_proto_err = 0, rd_mem_rst = 0, rd_issue = 0, rd_strobe_edge = 0;
  logic wr_dec_err = 0, wr_proto_err = 0, wr_mem_rst = 0;
  logic ar_ready, aw_ready;
  logic [1:0] rresp, bresp;
  logic [31:0] status;
  int total = 0, bad = 0;
  logic [3:0] last_rd = 0;
  logic [2:0] last_wr = 0;

  always #5 clk = ~clk;

  axi_txn_monitor #(.STALL_CYCLES(STALL)) uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] code(input logic dec, input logic other);
    return dec ? 2'b11 : (other ? 2'b10 : 2'b00);
  endfunction

  function automatic logic [31:0] word(input logic rb, input logic [3:0] rf,
                                       input logic wb, input logic [2:0] wf);
    return {5'b0, wf, 7'b0, wb, 4'b0, rf, 7'b0, rb};
  endfunction

  task automatic do_read(input logic [2:0] e, input logic stall, input int beats);
    @(negedge clk);
    check("R3 ar_ready idle", ar_ready, 1);
    ar_valid = 1;
    @(negedge clk);
    ar_valid = 0;
    check("R1 busy after AR", status, word(1, last_rd, 0, last_wr));
    check("R3 ar_ready busy", ar_ready, 0);
    {rd_mem_rst, rd_proto_err, rd_dec_err} = e;
    rd_issue = 1;
    @(negedge clk);
    rd_issue = 0;
    rd_strobe_edge = !stall;
    @(negedge clk);
    rd_strobe_edge = 0;
    repeat (STALL + 1) @(negedge clk);
    for (int i = 0; i < beats; i++) begin
      r_valid = 1; r_ready = 1; r_last = (i == beats - 1);
      #1;
      check("R6 R7 rresp", rresp, code(e[0], stall | e[1] | e[2]));
      @(negedge clk);
      if (i < beats - 1) check("R1 busy mid-burst", status[0], 1);
    end
    r_valid = 0; r_ready = 0; r_last = 0;
    last_rd = {stall, e};
    check("R1 R4 R7 R8 status after read", status, word(0, last_rd, 0, last_wr));
    {rd_mem_rst, rd_proto_err, rd_dec_err} = 0;
  endtask

  task automatic do_write(input logic [2:0] e);
    @(negedge clk);
    check("R3 aw_ready idle", aw_ready, 1);
    aw_valid = 1;
    @(negedge clk);
    aw_valid = 0;
    check("R2 busy after AW", status, word(0, last_rd, 1, last_wr));
    check("R3 aw_ready busy", aw_ready, 0);
    {wr_mem_rst, wr_proto_err, wr_dec_err} = e;
    @(negedge clk);
    b_valid = 1; b_ready = 1;
    #1;
    check("R6 bresp", bresp, code(e[0], e[1] | e[2]));
    @(negedge clk);
    b_valid = 0; b_ready = 0;
    last_wr = e;
    check("R2 R5 R8 status after write", status, word(0, last_rd, 0, last_wr));
    {wr_mem_rst, wr_proto_err, wr_dec_err} = 0;
  endtask

  initial begin
    #10000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    check("R9 reset word", status, 0);
    repeat (3) @(negedge clk);
    rd_mem_rst = 1; wr_dec_err = 1;
    @(negedge clk);
    check("R9 idle inputs ignored", status, 0);
    rd_mem_rst = 0; wr_dec_err = 0;
    rst_n = 1;
    @(negedge clk);
    check("R9 after reset release", status, 0);
    for (int s = 0; s < 2; s++)
      for (int e = 0; e < 8; e++)
        do_read(3'(e), s[0], 1 + (e % 3));
    for (int e = 7; e >= 0; e--) do_write(3'(e));
    do_read(3'b101, 1, 2);
    do_write(3'b010);
    check("R9 reserved bits zero", status & 32'hF8FE_F0FE, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule